// File: doc/BRIEF.md
# Asynchronous memory bank timing controller

This block runs single read and write transfers on an asynchronous external memory bus with up to four banks, such as parallel flash or asynchronous SRAM. An internal requester presents one request at a time: an address, a direction and write data. The two upper address bits choose the bank. The controller then drives the active-low bank selects, an access-window enable, and the read and write strobes. It holds the address and write data steady for the whole access and returns read data with a single done pulse.

Each bank has its own 16-bit timing word, so fast and slow devices can share the bus. The word sets the cycles before the strobe, the strobe width for reads and for writes, the cycles after the strobe, and a turnaround gap. The gap is inserted only when a read is followed by a write to the same bank, or by a read from another bank. A bank can also let the device stretch the strobe through a ready input, with either polarity. A 3-bit field decides how many banks are enabled. A request to a disabled bank, or to an access whose width code is zero, ends at once with an error and leaves the bus quiet.

Top module: `async_mem_ctrl`

## Requirements
- R1: The bank is `req_addr[ADDR_W-1:ADDR_W-2]`. While `mem_en_n` is low, exactly bit `bank` of `mem_sel_n` is low. `mem_addr` (the low `ADDR_W-2` request address bits) and, for writes, `mem_wdata` with `mem_dout_en` high stay constant.
- R2: Timing word bits [5:4] set the setup count: cycles with `mem_en_n` low before the strobe. Code 0 means 4 cycles and codes 1 to 3 mean 1 to 3 cycles.
- R3: Timing word bits [11:8] set the read strobe width in cycles (`mem_re_n` low) and bits [15:12] set the write strobe width (`mem_we_n` low), from 1 to 15 cycles.
- R4: Timing word bits [7:6] give 0 to 3 cycles with `mem_en_n` still low after the strobe ends.
- R5: After a completed read, a request that is a write to the same bank, or a read from a different bank, sees `mem_en_n` stay high for G cycles before setup. G comes from bits [3:2] of the bank just read: code 0 means 4 and codes 1 to 3 mean 1 to 3. Any other sequence starts setup in the cycle after acceptance.
- R6: When bit [0] (ready enable) is 1, `mem_rdy` is sampled in the last strobe cycle and in each later one. The strobe ends after the first cycle in which `mem_rdy` equals bit [1] (completing level). When bit [0] is 0, `mem_rdy` has no effect on the strobe width.
- R7: Bank enable `cfg_ben`: 000 enables no bank, 001 enables bank 0, 010 enables banks 0 and 1, 011 enables banks 0 to 2, and 1xx enables all four banks.
- R8: A request to a disabled bank, or with a strobe width code of 0 for its direction, raises `done` and `done_err` in the cycle after acceptance. No select, enable or strobe is asserted for it.
- R9: `req_ready` is high only when the controller is idle. After a good transfer, `done` is high for one cycle right after the last hold cycle, with `done_err` low. For reads, `done_rdata` carries `mem_rdata` as sampled in the last strobe cycle.
- R10: `mem_re_n` and `mem_we_n` are never low together, and a strobe is low only while `mem_en_n` is low. A read uses only `mem_re_n` and a write only `mem_we_n`.
- R11: During and right after reset, all selects, `mem_en_n`, `mem_re_n` and `mem_we_n` are high, `done` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_timing | input | 64 | Timing words, bank b at bits [16b+15:16b] |
| cfg_ben | input | 3 | Bank enable field |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address, upper two bits select the bank |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion was a rejected request |
| done_rdata | output | DATA_W | Read data returned with done |
| mem_sel_n | output | 4 | Active-low bank selects |
| mem_en_n | output | 1 | Active-low access-window enable |
| mem_re_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_addr | output | ADDR_W-2 | Bus address |
| mem_wdata | output | DATA_W | Bus write data |
| mem_dout_en | output | 1 | Write data drive enable |
| mem_rdata | input | DATA_W | Bus read data |
| mem_rdy | input | 1 | Device ready |

## Verification
The completion of one transfer and the acceptance of the next fall in the same cycle. In that cycle `done` is high and `req_ready` is already high again. The turnaround decision for the new request must use the read that is finishing at that very edge. The bench issues each new request in the done cycle, so requests come back to back across read, write and bank changes. Some requests are rejected; these complete and are accepted again with no gap and must not disturb the stored last-read state. The bench judges each case by counting the high `mem_en_n` cycles before setup and comparing them with its own record of the previous good transfer.

// File: rtl/amc_pkg.sv
package amc_pkg;

  localparam int TIM_W = 16;

  typedef struct packed {
    logic       rdy_en;
    logic       rdy_pol;
    logic [2:0] gap;
    logic [2:0] setup;
    logic [1:0] hold;
    logic [3:0] rd_acc;
    logic [3:0] wr_acc;
  } bank_tim_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GAP, ST_SETUP, ST_STRB, ST_WAIT, ST_HOLD
  } seq_st_t;

  // two-bit code where zero stands for four cycles
  function automatic logic [2:0] code_to_cyc(input logic [1:0] c);
    return (c == 2'd0) ? 3'd4 : {1'b0, c};
  endfunction

endpackage

// File: rtl/amc_tim_decode.sv
module amc_tim_decode
  import amc_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic [NBANK*TIM_W-1:0] cfg_timing,
  input  logic [2:0]             cfg_ben,
  output bank_tim_t              tim [NBANK],
  output logic [NBANK-1:0]       bank_on
);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [2:0] BIDX = 3'(b);
    logic [TIM_W-1:0] w;
    assign w = cfg_timing[b*TIM_W +: TIM_W];
    assign tim[b] = '{rdy_en:  w[0],
                      rdy_pol: w[1],
                      gap:     code_to_cyc(w[3:2]),
                      setup:   code_to_cyc(w[5:4]),
                      hold:    w[7:6],
                      rd_acc:  w[11:8],
                      wr_acc:  w[15:12]};
    assign bank_on[b] = cfg_ben[2] | (BIDX < {1'b0, cfg_ben[1:0]});
  end

endmodule

// File: rtl/amc_seq.sv
module amc_seq
  import amc_pkg::*;
#(
  parameter int LOW_W  = 18,
  parameter int DATA_W = 16,
  parameter int BANK_W = 2,
  parameter int NBANK  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [LOW_W-1:0]  req_low,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BANK_W-1:0] req_bank,
  input  bank_tim_t         req_tim,
  input  logic              bank_ok,
  output logic              req_ready,
  output logic              done,
  output logic              done_err,
  output logic [DATA_W-1:0] done_rdata,
  output logic [NBANK-1:0]  mem_sel_n,
  output logic              mem_en_n,
  output logic              mem_re_n,
  output logic              mem_we_n,
  output logic [LOW_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rdy
);

  seq_st_t           st, st_n;
  logic [3:0]        cnt, cnt_n;
  bank_tim_t         tim_q;
  logic [BANK_W-1:0] bank_q, last_bank, bank_nx;
  logic              is_wr, wr_nx, last_rd;
  logic [2:0]        last_gap;
  logic              take, rej, fin, cap, need_gap, win_nx, strb_nx;
  logic [NBANK-1:0]  sel_oh;

  assign req_ready = (st == ST_IDLE);
  assign need_gap  = last_rd &&
                     (req_write ? (req_bank == last_bank) : (req_bank != last_bank));

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    take  = 1'b0;
    rej   = 1'b0;
    fin   = 1'b0;
    cap   = 1'b0;
    case (st)
      ST_IDLE: if (req_valid) begin
        if (!bank_ok) rej = 1'b1;
        else begin
          take = 1'b1;
          if (need_gap) begin
            st_n  = ST_GAP;
            cnt_n = {1'b0, last_gap} - 4'd1;
          end else begin
            st_n  = ST_SETUP;
            cnt_n = {1'b0, req_tim.setup} - 4'd1;
          end
        end
      end
      ST_GAP: begin
        if (cnt == 4'd0) begin
          st_n  = ST_SETUP;
          cnt_n = {1'b0, tim_q.setup} - 4'd1;
        end else cnt_n = cnt - 4'd1;
      end
      ST_SETUP: begin
        if (cnt == 4'd0) begin
          st_n  = ST_STRB;
          cnt_n = (is_wr ? tim_q.wr_acc : tim_q.rd_acc) - 4'd1;
        end else cnt_n = cnt - 4'd1;
      end
      ST_STRB: begin
        if (cnt != 4'd0) cnt_n = cnt - 4'd1;
        else if (tim_q.rdy_en && (mem_rdy != tim_q.rdy_pol)) st_n = ST_WAIT;
        else cap = 1'b1;
      end
      ST_WAIT: if (mem_rdy == tim_q.rdy_pol) cap = 1'b1;
      ST_HOLD: begin
        if (cnt == 4'd0) begin
          st_n = ST_IDLE;
          fin  = 1'b1;
        end else cnt_n = cnt - 4'd1;
      end
      default: st_n = ST_IDLE;
    endcase
    if (cap) begin
      if (tim_q.hold == 2'd0) begin
        st_n = ST_IDLE;
        fin  = 1'b1;
      end else begin
        st_n  = ST_HOLD;
        cnt_n = {2'b00, tim_q.hold} - 4'd1;
      end
    end
  end

  assign bank_nx = take ? req_bank : bank_q;
  assign wr_nx   = take ? req_write : is_wr;
  assign win_nx  = (st_n == ST_SETUP) || (st_n == ST_STRB) ||
                   (st_n == ST_WAIT)  || (st_n == ST_HOLD);
  assign strb_nx = (st_n == ST_STRB) || (st_n == ST_WAIT);

  always_comb begin
    sel_oh          = '0;
    sel_oh[bank_nx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      tim_q       <= '0;
      bank_q      <= '0;
      is_wr       <= 1'b0;
      last_rd     <= 1'b0;
      last_bank   <= '0;
      last_gap    <= 3'd4;
      done        <= 1'b0;
      done_err    <= 1'b0;
      done_rdata  <= '0;
      mem_sel_n   <= '1;
      mem_en_n    <= 1'b1;
      mem_re_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      mem_dout_en <= 1'b0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
      if (take) begin
        tim_q     <= req_tim;
        bank_q    <= req_bank;
        is_wr     <= req_write;
        mem_addr  <= req_low;
        mem_wdata <= req_wdata;
      end
      if (cap && !is_wr) done_rdata <= mem_rdata;
      if (fin) begin
        last_rd   <= !is_wr;
        last_bank <= bank_q;
        last_gap  <= tim_q.gap;
      end
      done        <= fin | rej;
      done_err    <= rej;
      mem_en_n    <= !win_nx;
      mem_sel_n   <= win_nx ? ~sel_oh : '1;
      mem_re_n    <= !(strb_nx && !wr_nx);
      mem_we_n    <= !(strb_nx && wr_nx);
      mem_dout_en <= win_nx && wr_nx;
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mem_re_n && !mem_we_n));

  // R10
  strobe_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_re_n || !mem_we_n) |-> !mem_en_n);

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_sel_n) && (mem_en_n == (&mem_sel_n)));

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_en_n && $past(!mem_en_n)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (mem_en_n && req_ready));

  // R8
  reject_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (done && done_err) |-> $past(mem_en_n));

endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl
  import amc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int BANK_W = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [(1<<BANK_W)*TIM_W-1:0]   cfg_timing,
  input  logic [2:0]                     cfg_ben,
  input  logic                           req_valid,
  input  logic                           req_write,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [DATA_W-1:0]              req_wdata,
  output logic                           req_ready,
  output logic                           done,
  output logic                           done_err,
  output logic [DATA_W-1:0]              done_rdata,
  output logic [(1<<BANK_W)-1:0]         mem_sel_n,
  output logic                           mem_en_n,
  output logic                           mem_re_n,
  output logic                           mem_we_n,
  output logic [ADDR_W-BANK_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]              mem_wdata,
  output logic                           mem_dout_en,
  input  logic [DATA_W-1:0]              mem_rdata,
  input  logic                           mem_rdy
);

  localparam int NBANK = 1 << BANK_W;
  localparam int LOW_W = ADDR_W - BANK_W;

  bank_tim_t         tim [NBANK];
  logic [NBANK-1:0]  bank_on;
  logic [BANK_W-1:0] req_bank;
  bank_tim_t         req_tim;
  logic              bank_ok;

  assign req_bank = req_addr[ADDR_W-1 -: BANK_W];
  assign req_tim  = tim[req_bank];
  assign bank_ok  = bank_on[req_bank] &&
                    (req_write ? (req_tim.wr_acc != 4'd0) : (req_tim.rd_acc != 4'd0));

  amc_tim_decode #(.NBANK(NBANK)) dec_i (
    .cfg_timing (cfg_timing),
    .cfg_ben    (cfg_ben),
    .tim        (tim),
    .bank_on    (bank_on)
  );

  amc_seq #(
    .LOW_W (LOW_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .NBANK(NBANK)
  ) seq_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_low    (req_addr[LOW_W-1:0]),
    .req_wdata  (req_wdata),
    .req_bank   (req_bank),
    .req_tim    (req_tim),
    .bank_ok    (bank_ok),
    .req_ready  (req_ready),
    .done       (done),
    .done_err   (done_err),
    .done_rdata (done_rdata),
    .mem_sel_n  (mem_sel_n),
    .mem_en_n   (mem_en_n),
    .mem_re_n   (mem_re_n),
    .mem_we_n   (mem_we_n),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_dout_en(mem_dout_en),
    .mem_rdata  (mem_rdata),
    .mem_rdy    (mem_rdy)
  );

endmodule

// File: tb/async_mem_ctrl_tb_top.sv
`timescale 1ns/1ps
module async_mem_ctrl_tb_top;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int LOW_W  = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [15:0]       cfg_h [4];
  logic [63:0]       cfg_timing;
  logic [2:0]        cfg_ben = 3'b100;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              req_ready, done, done_err;
  logic [DATA_W-1:0] done_rdata, mem_wdata, mem_rdata;
  logic [3:0]        mem_sel_n;
  logic              mem_en_n, mem_re_n, mem_we_n, mem_dout_en;
  logic [LOW_W-1:0]  mem_addr;
  logic              mem_rdy = 1'b1;

  assign cfg_timing = {cfg_h[3], cfg_h[2], cfg_h[1], cfg_h[0]};

  function automatic logic [15:0] pat(input logic [LOW_W-1:0] a);
    return a[15:0] ^ {a[7:0], a[15:8]} ^ 16'hA55A;
  endfunction
  assign mem_rdata = pat(mem_addr);

  async_mem_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(2)) dut_i (
    .clk(clk), .rst(rst), .cfg_timing(cfg_timing), .cfg_ben(cfg_ben),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
    .done_err(done_err), .done_rdata(done_rdata), .mem_sel_n(mem_sel_n),
    .mem_en_n(mem_en_n), .mem_re_n(mem_re_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_dout_en(mem_dout_en),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
  );

  int errors = 0, checks = 0, cycles = 0;
  bit m_last_rd = 1'b0;
  int m_last_bank = 0, m_last_gap = 4;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cyc2(input logic [1:0] c);
    return (c == 2'd0) ? 4 : int'(c);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // called at a negedge; returns at the negedge of the done cycle
  task automatic txn(input bit wr, input logic [ADDR_W-1:0] a,
                     input logic [15:0] wd, input int w);
    int bank, acc, exp_gap, lead, su, sw, ho, got;
    bit ena, ok, selbad, addrbad, both, dirbad, late, derr;
    logic [15:0] h, dr;
    bank = int'(a[ADDR_W-1 -: 2]);
    h    = cfg_h[bank];
    ena  = cfg_ben[2] || (bank < int'(cfg_ben[1:0]));
    acc  = wr ? int'(h[15:12]) : int'(h[11:8]);
    ok   = ena && (acc != 0);
    exp_gap = (m_last_rd && (wr ? (bank == m_last_bank) : (bank != m_last_bank)))
              ? m_last_gap : 0;
    chk(req_ready, "R9 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    lead = 0; su = 0; sw = 0; ho = 0; got = 0; derr = 0; dr = '0;
    selbad = 0; addrbad = 0; both = 0; dirbad = 0; late = 0;
    for (int k = 0; k < 80; k++) begin
      if (done) begin
        got = 1; derr = done_err; dr = done_rdata;
        break;
      end
      if (mem_en_n) begin
        if (!mem_re_n || !mem_we_n) both = 1;
        if (mem_sel_n != 4'hF) selbad = 1;
        if (su + sw + ho != 0) late = 1;
        lead++;
      end else begin
        if (mem_sel_n != ~(4'b0001 << bank)) selbad = 1;
        if (mem_addr != a[LOW_W-1:0]) addrbad = 1;
        if (wr && (mem_wdata != wd || !mem_dout_en)) addrbad = 1;
        if (!mem_re_n && !mem_we_n) both = 1;
        if (!mem_re_n || !mem_we_n) begin
          if (wr ? !mem_re_n : !mem_we_n) dirbad = 1;
          sw++;
          mem_rdy = (sw < acc + w) ? !h[1] : h[1];
        end else if (sw == 0) su++;
        else ho++;
      end
      @(negedge clk);
    end
    if (!ok) begin
      chk(got == 1 && derr, ena ? "R8 zero width rejected" : "R7 disabled bank rejected",
          int'(derr), 1);
      chk(lead + su + sw + ho == 0 && !selbad && !both, "R8 bus quiet on reject",
          lead + su + sw + ho, 0);
    end else begin
      chk(got == 1 && !derr && !late, "R9 done after hold", int'(derr), 0);
      chk(lead == exp_gap, "R5 turnaround gap", lead, exp_gap);
      chk(su == cyc2(h[5:4]), "R2 setup cycles", su, cyc2(h[5:4]));
      chk(sw == acc + (h[0] ? w : 0), h[0] ? "R6 ready stretch" : "R3 strobe width",
          sw, acc + (h[0] ? w : 0));
      chk(ho == int'(h[7:6]), "R4 hold cycles", ho, int'(h[7:6]));
      chk(!selbad && !addrbad, "R1 select and address", int'(selbad) + int'(addrbad), 0);
      chk(!both && !dirbad, "R10 strobe use", int'(both) + int'(dirbad), 0);
      if (!wr) chk(dr == pat(a[LOW_W-1:0]), "R9 read data", int'(dr), int'(pat(a[LOW_W-1:0])));
      m_last_rd = !wr; m_last_bank = bank; m_last_gap = cyc2(h[3:2]);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int bank, input int low);
    return {2'(bank), 18'(low)};
  endfunction

  initial begin
    int unsigned seed;
    seed = $urandom(32'd60721);
    cfg_h[0] = 16'h2356; cfg_h[1] = 16'h1100; cfg_h[2] = 16'hF5F4; cfg_h[3] = 16'h40AC;
    @(negedge clk);
    chk(mem_sel_n == 4'hF && mem_en_n && mem_re_n && mem_we_n && !done,
        "R11 outputs in reset", int'(mem_sel_n), 15);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !done && mem_en_n && mem_sel_n == 4'hF, "R11 idle after reset",
        int'(req_ready), 1);

    // directed: turnaround rules, back to back
    txn(0, mk(0, 18'h00123), 16'h0, 0);
    txn(1, mk(0, 18'h00124), 16'hBEEF, 0);   // R5 read then write same bank
    txn(0, mk(0, 18'h00125), 16'h0, 0);
    txn(1, mk(1, 18'h01000), 16'h1234, 0);   // read then write other bank: no gap
    txn(0, mk(1, 18'h01001), 16'h0, 0);
    txn(0, mk(2, 18'h20002), 16'h0, 0);      // read other bank: gap of bank 1 (4)
    txn(0, mk(2, 18'h20003), 16'h0, 0);      // same bank read: no gap
    txn(1, mk(2, 18'h20004), 16'hCAFE, 0);   // write same bank: gap
    txn(1, mk(3, 18'h3FFFF), 16'h5555, 0);   // write with read code zero is fine
    txn(0, mk(3, 18'h3FFFE), 16'h0, 0);      // R8 read width code zero
    // R7 bank enable sweep
    for (int be = 0; be < 5; be++) begin
      cfg_ben = 3'(be);
      for (int b = 0; b < 3; b++) txn(0, mk(b, 18'h00400 + b), 16'h0, 0);
    end
    cfg_ben = 3'b100;
    // R6 ready stretch, both polarities, and ignore when disabled
    cfg_h[0] = 16'h2357;  txn(0, mk(0, 18'h00777), 16'h0, 3);
    cfg_h[0] = 16'h2355;  txn(1, mk(0, 18'h00778), 16'h7777, 2);
    cfg_h[0] = 16'h2356;  txn(0, mk(0, 18'h00779), 16'h0, 3);
    // random traffic
    for (int n = 0; n < 400; n++) begin
      if (($urandom % 8) == 0) begin
        int bsel;
        logic [15:0] h;
        bsel = int'($urandom % 4);
        h = 16'($urandom);
        if (h[11:8] == 4'd0 && ($urandom % 4) != 0) h[11:8] = 4'd1;
        if (h[15:12] == 4'd0 && ($urandom % 4) != 0) h[15:12] = 4'd2;
        cfg_h[bsel] = h;
      end
      cfg_ben = (($urandom % 6) == 0) ? 3'($urandom) : 3'b100;
      mem_rdy = 1'($urandom);
      repeat ($urandom % 3) @(negedge clk);
      txn(1'($urandom), 20'($urandom), 16'($urandom), int'($urandom % 4));
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule